// File: doc/BRIEF.md
# Decimal64 Operand Unpacker

This block accepts one 64-bit decimal floating-point word in the interchange format that stores the coefficient as densely packed decimal. From it, the block takes the sign, the true signed exponent and a 16-digit BCD coefficient. It also raises flags that mark a not-a-number, an infinity or a zero value. Downstream decimal arithmetic uses these fields directly, so it never has to look at the packed encoding.

The word splits into five parts. The sign sits at bit 63. Bits 62:58 hold the five leading combination bits. Bits 57:50 hold the exponent continuation. Bits 49:0 hold five 10-bit declets, and declet k sits at bits 10k+9:10k. The leading combination bits carry the two upper exponent bits and the leading coefficient digit, or they mark a special value. Each declet expands to three BCD digits. A single register stage sits between input and output, and a valid bit travels alongside the data. There is no back-pressure.

Top module: `dec64_unpack`

## Requirements
- R1: `out_sign` is a copy of bit 63 of the captured word, where 1 means negative.
- R2: When bits 62:61 are not both 1, bits 62:61 form the two upper biased-exponent bits and bits 60:58 form the leading digit, with a value from 0 to 7.
- R3: When bits 62:61 are 11 and bits 60:59 are not 11, bits 60:59 form the two upper biased-exponent bits and the leading digit is 8 plus bit 58.
- R4: For a finite operand, `out_exp` is the 10-bit two's-complement value of the biased exponent minus 398. The biased exponent is the two upper bits joined with bits 57:50. The result therefore spans -398 to +369.
- R5: `out_coef` holds 16 BCD digits. The leading digit sits in bits 63:60, and declet k supplies bits 12k+11:12k, with its hundreds digit placed highest.
- R6: Every one of the 1024 declet codes decodes as follows, where b3 is the indicator bit:
  - b3=0 gives the digits {b9b8b7}, {b6b5b4}, {b2b1b0}.
  - When b3=1, bits b2:b1 pick which digits are large (8 or 9, that is 8 + the low bit b7, b4 or b0 of that digit):
    - 00: only the units digit is large.
    - 01: only the tens digit is large, and the units digit becomes {b6b5b0}.
    - 10: only the hundreds digit is large, and the units digit becomes {b9b8b0}.
  - When b3=1 and b2:b1 are 11, bits b6:b5 pick the large digits:
    - 00: the hundreds and tens digits are large, and the units digit becomes {b9b8b0}.
    - 01: the hundreds and units digits are large, and the tens digit becomes {b9b8b4}.
    - 10: the tens and units digits are large.
    - 11: all three digits are large, whatever b9:b8 hold.
- R7: When bits 62:58 are 11110, `out_inf` is raised and `out_nan` and `out_zero` stay low. `out_exp` reads 0, the leading digit reads 0, and the declets are still decoded.
- R8: When bits 62:58 are 11111, `out_nan` is raised whatever bit 57 holds, and `out_inf` and `out_zero` stay low. `out_exp` reads 0, the leading digit reads 0, and the declets are still decoded.
- R9: `out_zero` is high exactly when the operand is finite and all 16 decoded digits are zero.
- R10: After a synchronous active-low reset, all outputs are zero. `out_valid` equals `in_valid` from one cycle earlier, and the data for a word shows one cycle after it was presented.
- R11: A cycle with `in_valid` low leaves every data output unchanged, whatever `in_word` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Marks `in_word` as an operand to capture |
| in_word | input | 64 | Packed decimal64 operand |
| out_valid | output | 1 | Outputs hold a freshly captured operand |
| out_sign | output | 1 | Sign, 1 means negative |
| out_exp | output | 10 | Unbiased exponent, two's complement |
| out_coef | output | 64 | 16 BCD coefficient digits, leading digit highest |
| out_nan | output | 1 | Operand is a NaN |
| out_inf | output | 1 | Operand is an infinity |
| out_zero | output | 1 | Operand is a finite zero |

## Verification
The decode path has no state, so a wrong decode appears at the ports on the very next cycle for the word that triggers it. The output fields show which part of the decode failed. A bad declet case gives wrong digits in exactly one 12-bit slice. A misread leading-bit prefix gives a wrong leading digit and an exponent that is off by a multiple of 256. A special-value slip shows up as a flag combination that should never occur. The only state is the output register. A capture-enable fault there shows up as data that changes during a cycle with valid low, one cycle after that cycle.

// File: rtl/dec64_pkg.sv
// Shared types for the decimal64 unpacker.
// Assumes the interchange layout: five leading combination bits, then
// an exponent continuation, then a run of 10-bit declets.
package dec64_pkg;

    // Result of decoding the five leading combination bits.
    typedef struct packed {
        logic [1:0] exp_top;   // upper two biased-exponent bits
        logic [3:0] lead_dig;  // leading coefficient digit
        logic       is_inf;
        logic       is_nan;
    } lead_info_t;

endpackage

// File: rtl/dec64_lead_decode.sv
// Decodes the five leading combination bits into the exponent top bits,
// the leading digit, and the special-value marks.
// Assumes a finite operand never carries 11 in both bit pairs.
module dec64_lead_decode
    import dec64_pkg::*;
(
    input  logic [4:0]  lead_bits,
    output lead_info_t  info
);

    // Pick the field layout from the two prefix pairs.
    always_comb begin
        info = '0;
        if (lead_bits[4:3] != 2'b11) begin
            info.exp_top  = lead_bits[4:3];
            info.lead_dig = {1'b0, lead_bits[2:0]};
        end else if (lead_bits[2:1] != 2'b11) begin
            info.exp_top  = lead_bits[2:1];
            info.lead_dig = {3'b100, lead_bits[0]};
        end else begin
            info.is_inf = ~lead_bits[0];
            info.is_nan =  lead_bits[0];
        end
    end

endmodule

// File: rtl/dpd_declet_decode.sv
// Expands one 10-bit densely packed declet into three BCD digits.
// The output is {hundreds, tens, units}. Non-canonical codes decode as
// if their two spare bits were zero.
module dpd_declet_decode (
    input  logic [9:0]  code,
    output logic [11:0] digits
);

    logic [3:0] hun, ten, uni;

    // Select the digit routing from the indicator bits.
    always_comb begin
        hun = {1'b0, code[9:7]};
        ten = {1'b0, code[6:4]};
        uni = {1'b0, code[2:0]};
        if (code[3]) begin
            unique case (code[2:1])
                2'b00: uni = {3'b100, code[0]};
                2'b01: begin
                    ten = {3'b100, code[4]};
                    uni = {1'b0, code[6:5], code[0]};
                end
                2'b10: begin
                    hun = {3'b100, code[7]};
                    uni = {1'b0, code[9:8], code[0]};
                end
                default: begin
                    unique case (code[6:5])
                        2'b00: begin
                            hun = {3'b100, code[7]};
                            ten = {3'b100, code[4]};
                            uni = {1'b0, code[9:8], code[0]};
                        end
                        2'b01: begin
                            hun = {3'b100, code[7]};
                            ten = {1'b0, code[9:8], code[4]};
                            uni = {3'b100, code[0]};
                        end
                        2'b10: begin
                            ten = {3'b100, code[4]};
                            uni = {3'b100, code[0]};
                        end
                        default: begin
                            hun = {3'b100, code[7]};
                            ten = {3'b100, code[4]};
                            uni = {3'b100, code[0]};
                        end
                    endcase
                end
            endcase
        end
    end

    assign digits = {hun, ten, uni};

endmodule

// File: rtl/dec64_unpack.sv
// Unpacks a densely packed decimal64 word into its sign, signed exponent,
// BCD coefficient and class flags, with one register stage.
// Assumes the exponent width is the continuation width plus two.
module dec64_unpack
    import dec64_pkg::*;
#(
    parameter  int N_DECLETS = 5,
    parameter  int ECONT_W   = 8,
    parameter  int BIAS      = 398,
    localparam int EXP_W     = ECONT_W + 2,
    localparam int DIGITS    = 3 * N_DECLETS + 1,
    localparam int COEF_W    = 4 * DIGITS,
    localparam int TRAIL_W   = 10 * N_DECLETS,
    localparam int WORD_W    = 1 + 5 + ECONT_W + TRAIL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    output logic              out_valid,
    output logic              out_sign,
    output logic [EXP_W-1:0]  out_exp,
    output logic [COEF_W-1:0] out_coef,
    output logic              out_nan,
    output logic              out_inf,
    output logic              out_zero
);

    localparam int LEAD_LSB = TRAIL_W + ECONT_W;
    localparam logic [EXP_W:0] BIAS_V = (EXP_W+1)'(BIAS);

    lead_info_t                 lead;
    logic [12*N_DECLETS-1:0]    trail_bcd;
    logic [COEF_W-1:0]          coef_d;
    logic [EXP_W-1:0]           biased;
    logic [EXP_W:0]             exp_full;
    logic [EXP_W-1:0]           exp_d;
    logic                       special;
    logic                       zero_d;

    dec64_lead_decode u_lead (
        .lead_bits (in_word[LEAD_LSB +: 5]),
        .info      (lead)
    );

    // One decoder per declet.
    for (genvar k = 0; k < N_DECLETS; k++) begin : g_declet
        dpd_declet_decode u_dpd (
            .code   (in_word[10*k +: 10]),
            .digits (trail_bcd[12*k +: 12])
        );
    end

    assign special  = lead.is_inf | lead.is_nan;
    assign coef_d   = {(special ? 4'd0 : lead.lead_dig), trail_bcd};
    assign biased   = {lead.exp_top, in_word[TRAIL_W +: ECONT_W]};
    assign exp_full = {1'b0, biased} - BIAS_V;
    assign exp_d    = special ? '0 : exp_full[EXP_W-1:0];
    assign zero_d   = ~special && (coef_d == '0);

    // Output stage: load on valid, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sign  <= 1'b0;
            out_exp   <= '0;
            out_coef  <= '0;
            out_nan   <= 1'b0;
            out_inf   <= 1'b0;
            out_zero  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_sign <= in_word[WORD_W-1];
                out_exp  <= exp_d;
                out_coef <= coef_d;
                out_nan  <= lead.is_nan;
                out_inf  <= lead.is_inf;
                out_zero <= zero_d;
            end
        end
    end

    // R7 R8 R9: at most one class flag is high.
    a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({out_nan, out_inf, out_zero}));

    // R4: a finite exponent stays inside the encodable range.
    a_r4_exp_range: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_nan && !out_inf) |->
            ($signed(out_exp) >= -$signed(BIAS_V) &&
             $signed(out_exp) <= $signed((EXP_W+1)'(3 * (1 << ECONT_W) - 1) - BIAS_V)));

    // R7 R8: special values report a zero exponent and a zero leading digit.
    a_r8_special_fields: assert property (@(posedge clk) disable iff (!rst_n)
        (out_nan || out_inf) |-> (out_exp == '0 && out_coef[COEF_W-1 -: 4] == 4'd0));

    // R11: data holds through a cycle without valid.
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_coef) && $stable(out_exp) && $stable(out_sign)));

    // R6: every output digit is a legal BCD digit.
    for (genvar g = 0; g < DIGITS; g++) begin : g_bcd_chk
        a_r6_digit_bcd: assert property (@(posedge clk) disable iff (!rst_n)
            out_coef[4*g +: 4] <= 4'd9);
    end

endmodule

// File: tb/test_dec64_unpack.sv
// Self-checking bench: sweeps all declet codes in every position and
// checks the special values and the exponent extremes against a
// reference built from a digit-to-declet encoder.
module test_dec64_unpack;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [63:0] in_word;
    logic        out_valid, out_sign, out_nan, out_inf, out_zero;
    logic [9:0]  out_exp;
    logic [63:0] out_coef;

    int n_cmp = 0;
    int n_bad = 0;
    logic [11:0] tab [1024];
    bit          seen [1024];

    always #4 clk = ~clk;

    dec64_unpack i_dec64_unpack (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
        .out_valid(out_valid), .out_sign(out_sign), .out_exp(out_exp),
        .out_coef(out_coef), .out_nan(out_nan), .out_inf(out_inf),
        .out_zero(out_zero)
    );

    // Digit triple to declet, the inverse direction of the design.
    function automatic logic [9:0] enc(logic [3:0] x, logic [3:0] y, logic [3:0] z);
        case ({x[3], y[3], z[3]})
            3'b000:  return {x[2:0], y[2:0], 1'b0, z[2:0]};
            3'b001:  return {x[2:0], y[2:0], 1'b1, 2'b00, z[0]};
            3'b010:  return {x[2:0], z[2:1], y[0], 1'b1, 2'b01, z[0]};
            3'b011:  return {x[2:0], 2'b10, y[0], 1'b1, 2'b11, z[0]};
            3'b100:  return {z[2:1], x[0], y[2:0], 1'b1, 2'b10, z[0]};
            3'b101:  return {y[2:1], x[0], 2'b01, y[0], 1'b1, 2'b11, z[0]};
            3'b110:  return {z[2:1], x[0], 2'b00, y[0], 1'b1, 2'b11, z[0]};
            default: return {2'b00, x[0], 2'b11, y[0], 1'b1, 2'b11, z[0]};
        endcase
    endfunction

    function automatic logic [63:0] build(logic s, logic [9:0] be, logic [3:0] msd, logic [49:0] trail);
        logic [4:0] lead;
        lead = (msd < 4'd8) ? {be[9:8], msd[2:0]} : {2'b11, be[9:8], msd[0]};
        return {s, lead, be[7:0], trail};
    endfunction

    function automatic logic [63:0] coef_of(logic [3:0] msd, logic [49:0] trail);
        logic [63:0] c;
        c[63:60] = msd;
        for (int k = 0; k < 5; k++) c[12*k +: 12] = tab[trail[10*k +: 10]];
        return c;
    endfunction

    task automatic check(string tag, logic v, logic s, logic [9:0] e, logic [63:0] c,
                         logic n, logic i, logic z);
        n_cmp++;
        if ({out_valid, out_sign, out_exp, out_coef, out_nan, out_inf, out_zero} !==
            {v, s, e, c, n, i, z}) begin
            n_bad++;
            $display("FAIL %s: got v=%b s=%b e=%0d c=%h n/i/z=%b%b%b exp v=%b s=%b e=%0d c=%h n/i/z=%b%b%b",
                     tag, out_valid, out_sign, $signed(out_exp), out_coef, out_nan, out_inf, out_zero,
                     v, s, $signed(e), c, n, i, z);
        end
    endtask

    // Drive a finite operand and compare one cycle later.
    task automatic finite(string tag, logic s, int be, logic [3:0] msd, logic [49:0] trail);
        logic [63:0] c;
        c = coef_of(msd, trail);
        in_word  = build(s, 10'(be), msd, trail);
        in_valid = 1'b1;
        @(negedge clk);
        check(tag, 1'b1, s, 10'(be - 398), c, 1'b0, 1'b0, c == 64'd0);
    endtask

    task automatic special(string tag, logic s, logic [4:0] lead, logic [7:0] cont, logic [49:0] trail);
        in_word  = {s, lead, cont, trail};
        in_valid = 1'b1;
        @(negedge clk);
        check(tag, 1'b1, s, 10'd0, coef_of(4'd0, trail), lead[0], ~lead[0], 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got no finish, expected end of run");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [49:0] tr;
        // Reference table: canonical codes from the encoder, rest by rule (R6).
        for (int d = 0; d < 1000; d++) begin
            logic [9:0] cd;
            cd = enc(4'(d / 100), 4'((d / 10) % 10), 4'(d % 10));
            tab[cd]  = {4'(d / 100), 4'((d / 10) % 10), 4'(d % 10)};
            seen[cd] = 1'b1;
        end
        for (int c = 0; c < 1024; c++)
            if (!seen[c]) tab[c] = {3'b100, c[7], 3'b100, c[4], 3'b100, c[0]};

        rst_n = 1'b0; in_valid = 1'b1; in_word = '1;
        repeat (3) @(negedge clk);
        check("R10 reset", 1'b0, 1'b0, 10'd0, 64'd0, 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;

        // R1 R2 R3 R4 R5 R6: every code in every declet position.
        for (int c = 0; c < 1024; c++) begin
            for (int k = 0; k < 5; k++) tr[10*k +: 10] = 10'((c + 205 * k) % 1024);
            finite("R1 R2 R3 R4 R5 R6 sweep", c[0], (c * 3) % 768, 4'(c % 10), tr);
        end

        // R4 R9: smallest exponent, zero coefficient, negative sign.
        finite("R4 R9 zero min exp", 1'b1, 0, 4'd0, 50'd0);
        // R4 R3 R6: largest exponent, all nines.
        finite("R3 R4 R6 max exp all nines", 1'b0, 767, 4'd9, {5{10'h0FF}});
        // R3: leading eight with exponent top bits 10.
        finite("R3 lead eight", 1'b0, 512, 4'd8, {5{10'h000}});
        // R2 R9: leading seven is not zero.
        finite("R2 R9 lead seven", 1'b0, 398, 4'd7, 50'd0);
        // R9: zero at the largest exponent.
        finite("R9 zero max exp", 1'b0, 767, 4'd0, 50'd0);

        // R7: both infinities, payload still decoded.
        special("R7 plus inf",  1'b0, 5'b11110, 8'h00, {5{10'h3FF}});
        special("R7 minus inf", 1'b1, 5'b11110, 8'h5A, 50'd0);
        // R8: quiet and signalling NaN.
        special("R8 quiet nan",      1'b0, 5'b11111, 8'h00, {5{10'h123}});
        special("R8 signalling nan", 1'b1, 5'b11111, 8'h80, 50'd0);

        // R10 R11: a gap cycle keeps data and drops valid.
        finite("R10 before gap", 1'b1, 100, 4'd5, {5{10'h2A5}});
        in_valid = 1'b0;
        in_word  = {1'b0, 5'b11111, 8'hFF, {5{10'h000}}};
        @(negedge clk);
        check("R10 R11 gap", 1'b0, 1'b1, 10'(100 - 398), coef_of(4'd5, {5{10'h2A5}}),
              1'b0, 1'b0, 1'b0);
        @(negedge clk);
        check("R11 second gap", 1'b0, 1'b1, 10'(100 - 398), coef_of(4'd5, {5{10'h2A5}}),
              1'b0, 1'b0, 1'b0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule